// File: doc/BRIEF.md
# Page Program Wrap Buffer

This block gathers the data bytes of a serial page-program command into an on-chip page buffer and then writes them to the memory array. A command opens with a start strobe that carries the target address. Its low bits give the first byte offset and its high bits select the page. Each received byte is stored at the current offset, and the offset steps up by one. Past the last offset it wraps to offset zero of the same page, so the page number never changes. A per-byte valid mask records which offsets were supplied. If more bytes arrive than the page holds, the later bytes replace the earlier ones.

When the deselect strobe arrives with the bit counter at a byte boundary and at least one byte collected, the block walks the page offsets in ascending order. For each offset set in the mask it presents an address and data pair on a valid/ready write port. Offsets that were not supplied produce no write, so the array keeps their old contents. A deselect in the middle of a byte, or one with no data bytes, drops the buffer and writes nothing. The mask clears once the walk ends.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset, `wr_valid_o` and `busy_o` are low.
- R2: After `start_i`, the k-th accepted byte (k from 0) goes to offset (start_addr_i[7:0] + k) mod 256. Every write address carries start_addr_i[16:8] as its upper bits, and the data byte on the port is the byte that was received.
- R3: From offset 255 the offset wraps to 0 of the same page. The page bits do not change.
- R4: With more than 256 bytes, each offset is written once, holding the last byte received for it.
- R5: An offset that received no byte in the command produces no write.
- R6: A deselect with `bit_cnt_i` nonzero (mid-byte) discards the command. No write follows and `busy_o` stays low.
- R7: A deselect after `start_i` with no byte received produces no write.
- R8: Writes come out in ascending offset order. While `wr_valid_o` is high and `wr_ready_i` is low, address and data hold steady.
- R9: After a commit or a discard, the mask is empty. A later command writes only its own bytes.
- R10: While `busy_o` is high, `start_i` and bytes are ignored. No command is opened, and `busy_o` is high from the cycle after a committing deselect until the walk ends.
- R11: Bytes and deselects that arrive without an open command produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a command, capturing `start_addr_i` |
| start_addr_i | input | 17 | Start address: page in [16:8], offset in [7:0] |
| byte_valid_i | input | 1 | One data byte is present |
| byte_data_i | input | 8 | Data byte |
| desel_i | input | 1 | Chip select has risen |
| bit_cnt_i | input | 3 | Bits received in the current byte; 0 is a byte boundary |
| wr_ready_i | input | 1 | Memory accepts the current write |
| wr_valid_o | output | 1 | Write pair valid |
| wr_addr_o | output | 17 | Write address |
| wr_data_o | output | 8 | Write data |
| busy_o | output | 1 | Commit walk in progress |

## Verification
The bench builds the block with its defaults: a 17-bit address, an 8-bit page offset and 8-bit data. This gives the full 256-entry page, so the wrap from offset 255 to 0 and runs longer than a page (up to 300 bytes) can both be reached. Random start addresses fall on many different pages, which exercises the page bits. Random ready stalls stretch the walk, and this gives the ignore-while-busy cases time to occur.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/ppb_collector.sv
module ppb_collector #(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3,
  localparam int PAGE  = 1 << PAGE_W,
  localparam int PG_W  = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              desel_i,
  input  logic [BIT_W-1:0]  bit_cnt_i,
  input  logic              busy_i,
  input  logic              clear_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [PAGE-1:0]   mask_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PG_W-1:0]   page_o,
  output logic              commit_o
);
  logic              fill_q;
  logic [PAGE_W-1:0] ptr_q;
  logic [PG_W-1:0]   page_q;
  logic [PAGE-1:0]   mask_q;
  logic [DATA_W-1:0] buf_q [PAGE];
  logic              start_ok, close, byte_take;

  assign start_ok  = start_i && !busy_i;
  assign close     = fill_q && desel_i && !start_ok;
  assign byte_take = fill_q && byte_valid_i && !desel_i && !start_ok;
  // commit only on a clean byte boundary with at least one byte held
  assign commit_o  = close && (bit_cnt_i == '0) && (|mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= 1'b0;
      ptr_q  <= '0;
      page_q <= '0;
      mask_q <= '0;
    end else begin
      if (clear_i) mask_q <= '0;
      if (start_ok) begin
        fill_q <= 1'b1;
        ptr_q  <= start_addr_i[PAGE_W-1:0];
        page_q <= start_addr_i[ADDR_W-1:PAGE_W];
        mask_q <= '0;
      end else if (close) begin
        fill_q <= 1'b0;
        if (!commit_o) mask_q <= '0;
      end else if (byte_take) begin
        mask_q[ptr_q] <= 1'b1;
        ptr_q         <= ptr_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_byte
    always_ff @(posedge clk_i) begin
      if (byte_take && (ptr_q == PAGE_W'(g))) buf_q[g] <= byte_data_i;
    end
  end

  assign mask_o    = mask_q;
  assign rd_data_o = buf_q[rd_idx_i];
  assign page_o    = page_q;
endmodule

// File: rtl/ppb_walker.sv
module ppb_walker
  import ppb_pkg::*;
#(
  parameter int PAGE_W = 8,
  localparam int PAGE  = 1 << PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [PAGE-1:0]   mask_i,
  input  logic              wr_ready_i,
  output logic [PAGE_W-1:0] idx_o,
  output logic              wr_valid_o,
  output logic              busy_o,
  output logic              done_o
);
  walk_state_e       state_q;
  logic [PAGE_W-1:0] idx_q;
  logic              run, adv;

  assign run        = (state_q == WALK_RUN);
  assign wr_valid_o = run && mask_i[idx_q];
  // skip empty offsets, otherwise advance on handshake
  assign adv        = run && (!mask_i[idx_q] || wr_ready_i);
  assign done_o     = adv && (idx_q == PAGE_W'(PAGE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WALK_IDLE;
      idx_q   <= '0;
    end else if (!run) begin
      if (go_i) begin
        state_q <= WALK_RUN;
        idx_q   <= '0;
      end
    end else if (adv) begin
      idx_q <= idx_q + 1'b1;
      if (done_o) state_q <= WALK_IDLE;
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = run;
endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer #(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W),
  localparam int PAGE  = 1 << PAGE_W,
  localparam int PG_W  = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              desel_i,
  input  logic [BIT_W-1:0]  bit_cnt_i,
  input  logic              wr_ready_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o
);
  logic [PAGE-1:0]   mask;
  logic [PAGE_W-1:0] idx;
  logic [PG_W-1:0]   page;
  logic              commit, busy, done;

  ppb_collector #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .BIT_W(BIT_W)
  ) u_collector (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .byte_valid_i (byte_valid_i),
    .byte_data_i  (byte_data_i),
    .desel_i      (desel_i),
    .bit_cnt_i    (bit_cnt_i),
    .busy_i       (busy),
    .clear_i      (done),
    .rd_idx_i     (idx),
    .mask_o       (mask),
    .rd_data_o    (wr_data_o),
    .page_o       (page),
    .commit_o     (commit)
  );

  ppb_walker #(.PAGE_W(PAGE_W)) u_walker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (commit),
    .mask_i     (mask),
    .wr_ready_i (wr_ready_i),
    .idx_o      (idx),
    .wr_valid_o (wr_valid_o),
    .busy_o     (busy),
    .done_o     (done)
  );

  assign wr_addr_o = {page, idx};
  assign busy_o    = busy;
endmodule

// File: rtl/ppb_checker.sv
module ppb_checker #(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              desel_i,
  input logic [BIT_W-1:0]  bit_cnt_i,
  input logic              wr_ready_i,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              busy_o
);
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R8

  AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_ready_i) |=> (!wr_valid_o || (wr_addr_o > $past(wr_addr_o)))); // R8

  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && busy_o) |=> (!wr_valid_o ||
      (wr_addr_o[ADDR_W-1:PAGE_W] == $past(wr_addr_o[ADDR_W-1:PAGE_W])))); // R3

  AST_VALID_IN_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> busy_o); // R10

  AST_MIDBYTE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desel_i && (bit_cnt_i != '0) && !busy_o) |=> !busy_o); // R6
endmodule

bind page_prog_buffer ppb_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .BIT_W(BIT_W)
) u_ppb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .desel_i    (desel_i),
  .bit_cnt_i  (bit_cnt_i),
  .wr_ready_i (wr_ready_i),
  .wr_valid_o (wr_valid_o),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .busy_o     (busy_o)
);

// File: tb/page_prog_buffer_bench.sv
module page_prog_buffer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [16:0] start_addr_i = '0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        desel_i = 1'b0;
  logic [2:0]  bit_cnt_i = '0;
  logic        wr_ready_i = 1'b0;
  logic        wr_valid_o;
  logic [16:0] wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        busy_o;

  int checks = 0;
  int failures = 0;
  int rdy_pct = 70;
  bit finished = 1'b0;

  logic [7:0]  pay [0:511];
  logic [7:0]  exp_d [0:255];
  bit          exp_v [0:255];
  logic [16:0] got_a [$];
  logic [7:0]  got_d [$];

  always #4 clk_i = ~clk_i;

  page_prog_buffer u_page_prog_buffer (.*);

  always @(negedge clk_i) begin
    wr_ready_i = (($urandom % 100) < rdy_pct);
    #1;
    if (rst_ni && wr_valid_o && wr_ready_i) begin
      got_a.push_back(wr_addr_o);
      got_d.push_back(wr_data_o);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic send_start(input logic [16:0] a);
    @(negedge clk_i);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic send_bytes(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) @(negedge clk_i);
      byte_valid_i = 1'b1; byte_data_i = pay[i];
      @(negedge clk_i);
      byte_valid_i = 1'b0;
    end
  endtask

  task automatic send_desel(input logic [2:0] bc);
    desel_i = 1'b1; bit_cnt_i = bc;
    @(negedge clk_i);
    desel_i = 1'b0; bit_cnt_i = '0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 5000 && busy_o; t++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  function automatic void build_exp(input logic [16:0] a, input int n);
    logic [7:0] p;
    for (int i = 0; i < 256; i++) exp_v[i] = 1'b0;
    p = a[7:0];
    for (int i = 0; i < n; i++) begin
      exp_d[p] = pay[i];
      exp_v[p] = 1'b1;
      p = p + 8'd1;
    end
  endfunction

  task automatic check_writes(input logic [8:0] pg, input bit commit, input string req);
    int k = 0;
    int ne = 0;
    if (commit) for (int i = 0; i < 256; i++) if (exp_v[i]) ne++;
    chk(got_a.size() == ne, req, "write count", got_a.size(), ne);
    if (commit && got_a.size() == ne) begin
      for (int i = 0; i < 256; i++) begin
        if (exp_v[i]) begin
          chk(got_a[k] == {pg, 8'(i)}, req, "write addr", got_a[k], {pg, 8'(i)});
          chk(got_d[k] == exp_d[i], req, "write data", got_d[k], exp_d[i]);
          k++;
        end
      end
    end
    got_a.delete(); got_d.delete();
  endtask

  task automatic run_cmd(input logic [16:0] a, input int n, input logic [2:0] bc, input string req);
    got_a.delete(); got_d.delete();
    send_start(a);
    send_bytes(n, 1'b1);
    send_desel(bc);
    wait_idle();
    build_exp(a, n);
    check_writes(a[16:8], (bc == 0) && (n > 0), req);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    repeat (195000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [16:0] a;
    int n;
    logic [2:0] bc;
    void'($urandom(32'd20031));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!wr_valid_o, "R1", "wr_valid after reset", wr_valid_o, 0);
    chk(!busy_o, "R1", "busy after reset", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 plain run mid-page
    for (int i = 0; i < 512; i++) pay[i] = 8'($urandom);
    run_cmd(17'h0A_C20, 7, 3'd0, "R2");
    // R3 wrap across offset 255
    run_cmd(17'h1_03FE, 4, 3'd0, "R3");
    // R4 overflow overwrites earliest bytes
    run_cmd(17'h0_5510, 260, 3'd0, "R4");
    // R5 single byte: only one write
    run_cmd(17'h1_FF80, 1, 3'd0, "R5");
    // R6 mid-byte deselect discards
    run_cmd(17'h0_2000, 5, 3'd3, "R6");
    // R9 next command writes only its own bytes
    run_cmd(17'h0_2004, 2, 3'd0, "R9");
    // R7 no data bytes
    run_cmd(17'h0_3333, 0, 3'd0, "R7");

    // R11 bytes and deselect with no open command
    got_a.delete(); got_d.delete();
    send_bytes(6, 1'b0);
    send_desel(3'd0);
    chk(!busy_o, "R11", "busy without command", busy_o, 0);
    wait_idle();
    chk(got_a.size() == 0, "R11", "writes without command", got_a.size(), 0);

    // R10 start and bytes during walk are ignored
    rdy_pct = 25;
    got_a.delete(); got_d.delete();
    send_start(17'h0_7700);
    send_bytes(40, 1'b0);
    send_desel(3'd0);
    chk(busy_o, "R10", "busy after commit", busy_o, 1);
    send_start(17'h1_1100);
    send_bytes(10, 1'b0);
    wait_idle();
    build_exp(17'h0_7700, 40);
    check_writes(9'h077, 1'b1, "R10");
    send_desel(3'd0);
    wait_idle();
    chk(got_a.size() == 0, "R10", "start during walk opened command", got_a.size(), 0);
    rdy_pct = 70;

    // R8 random stream with stalls
    for (int it = 0; it < 20; it++) begin
      a  = 17'($urandom);
      n  = 1 + ($urandom % 300);
      bc = ($urandom % 4 == 0) ? 3'(1 + $urandom % 7) : 3'd0;
      for (int i = 0; i < 512; i++) pay[i] = 8'($urandom);
      rdy_pct = 30 + ($urandom % 70);
      run_cmd(a, n, bc, "R8");
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule